// File: doc/BRIEF.md
# Flash Erase Command Controller

This block is the control core of a byte-wide flash device, modelled as clocked logic. The chip-enable, write-enable and output-enable strobes arrive with no timing relation to the clock. The block passes them through synchronizer chains and builds bus write cycles from them. A write takes its address at the moment the second of the two enables goes low, and its data at the moment the first of them goes high again.

A decoder watches the stream of completed writes for a six-write unlock-and-command sequence. The sequence selects either an erase of the whole array or an erase of one sector. An erase sequencer turns the selected work into a list of regions, in ascending address order. It asks an external array to clear one region at a time, and it times each region with an internal countdown. A protected boot sector is skipped whenever the lockout input is high. While an erase runs, the busy flag is high and every bus write is dropped. A synchronous reset aborts the erase and returns the block to read mode.

Top module: `flash_erase_ctrl`

## Requirements
- R1: A bus write is counted only while output-enable is high and chip-enable and write-enable are both low. Its address is the value present when the later of the two enables falls. Its data is the value present when the earlier of the two rises. A strobe pulse made with output-enable low does not count as a write.
- R2: `dout_en` is 1 exactly when reset is low, `ce_n` is 0, `oe_n` is 0 and `we_n` is 1. In every other case it is 0, which tri-states the data outputs.
- R3: The unlock prefix is five writes (address/data): 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55. A sixth write of 0x10 to 0x5555 starts a chip erase. Addresses are compared over all address bits.
- R4: A sixth write of data 0x30 starts an erase of the sector that holds that write's address. A sixth write with any other data, except 0x10 at 0x5555, starts nothing.
- R5: A write that does not match the next expected step sends the decoder back to the first step. So does a write of 0xF0 at any step. The writes that follow then start nothing unless they form a complete new sequence.
- R6: The sectors, with a 17-bit address, are: boot 0x00000–0x03FFF, param A 0x04000–0x05FFF, param B 0x06000–0x07FFF, main A 0x08000–0x0FFFF, main B 0x10000–0x1FFFF. A sector erase reports exactly that sector's first and last address.
- R7: With `boot_lock` high, a chip erase clears every sector except boot, and a sector erase aimed at boot starts nothing and leaves `busy` low. With `boot_lock` low, a chip erase clears all five sectors.
- R8: Regions are requested one at a time, in ascending address order. Each request is a one-cycle `ers_start` pulse. `ers_first` and `ers_last` hold the region bounds from that pulse until the next one.
- R9: Successive `ers_start` pulses of one erase are ERASE_CYCLES+1 cycles apart. `busy` stays high for exactly regions×(ERASE_CYCLES+1) cycles and covers every pulse.
- R10: Every bus write made while `busy` is high is ignored. When the erase ends, the decoder is at its first step and reads are enabled again.
- R11: Reset clears `busy` on the next cycle and abandons any remaining regions, so no further `ers_start` follows. It also clears a partly entered sequence. After reset is released, the block is in read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also aborts an erase |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Bus address |
| din | input | 8 | Bus write data |
| boot_lock | input | 1 | Static boot-sector protection |
| dout_en | output | 1 | Data output drive enable (0 = high impedance) |
| busy | output | 1 | Erase in progress |
| ers_start | output | 1 | One-cycle request to clear a region |
| ers_first | output | ADDR_W | First address of the requested region |
| ers_last | output | ADDR_W | Last address of the requested region |

## Verification
The bench builds the block with the default 17-bit address and two synchronizer stages, but shortens ERASE_CYCLES to 20. With that setting a full five-region chip erase fits in about a hundred cycles. This puts within reach every sector erase at each sector's lowest, highest and middle address, under both lockout settings, and both chip erase variants. A complete command sequence can also be entered while an erase is still running, and a reset can land between two region requests. Expected bounds, region order and busy lengths are derived in the bench from the sector sizes as powers of two.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    localparam int BYTE_W    = 8;
    localparam int WIDE_W    = 32;
    localparam int N_SECTORS = 5;
    localparam int LAST_STEP = 5;

    localparam logic [WIDE_W-1:0] ADR_KEY_A = 32'h0000_5555;
    localparam logic [WIDE_W-1:0] ADR_KEY_B = 32'h0000_2AAA;

    localparam logic [BYTE_W-1:0] DAT_KEY_A  = 8'hAA;
    localparam logic [BYTE_W-1:0] DAT_KEY_B  = 8'h55;
    localparam logic [BYTE_W-1:0] DAT_SETUP  = 8'h80;
    localparam logic [BYTE_W-1:0] DAT_CHIP   = 8'h10;
    localparam logic [BYTE_W-1:0] DAT_SECTOR = 8'h30;
    localparam logic [BYTE_W-1:0] DAT_ABORT  = 8'hF0;

    typedef enum logic [2:0] {
        SEC_BOOT  = 3'd0,
        SEC_PARA  = 3'd1,
        SEC_PARB  = 3'd2,
        SEC_MAINA = 3'd3,
        SEC_MAINB = 3'd4
    } sector_e;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_CHIP   = 2'd1,
        OP_SECTOR = 2'd2
    } op_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [WIDE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } bus_wr_t;

    typedef struct packed {
        logic              valid;
        op_kind_e          kind;
        logic [WIDE_W-1:0] addr;
    } erase_cmd_t;

    // Lowest address of a sector for an array of 2**aw bytes.
    function automatic logic [WIDE_W-1:0] sector_lo(input int aw, input int idx);
        logic [WIDE_W-1:0] eighth, sixteenth;
        eighth    = 32'd1 << (aw - 3);
        sixteenth = 32'd1 << (aw - 4);
        case (idx)
            0:       sector_lo = '0;
            1:       sector_lo = eighth;
            2:       sector_lo = eighth + sixteenth;
            3:       sector_lo = 32'd1 << (aw - 2);
            default: sector_lo = 32'd1 << (aw - 1);
        endcase
    endfunction

    function automatic logic [WIDE_W-1:0] sector_hi(input int aw, input int idx);
        if (idx >= N_SECTORS - 1)
            sector_hi = (32'd1 << aw) - 32'd1;
        else
            sector_hi = sector_lo(aw, idx + 1) - 32'd1;
    endfunction

    function automatic sector_e sector_of(input int aw, input logic [WIDE_W-1:0] a);
        sector_e s;
        s = SEC_BOOT;
        for (int i = 1; i < N_SECTORS; i++) begin
            if (a >= sector_lo(aw, i)) s = sector_e'(i);
        end
        return s;
    endfunction

    // Address/data pair expected at each step of the unlock prefix.
    function automatic logic prefix_ok(input logic [2:0] step, input bus_wr_t w);
        case (step)
            3'd0:    prefix_ok = (w.addr == ADR_KEY_A) && (w.data == DAT_KEY_A);
            3'd1:    prefix_ok = (w.addr == ADR_KEY_B) && (w.data == DAT_KEY_B);
            3'd2:    prefix_ok = (w.addr == ADR_KEY_A) && (w.data == DAT_SETUP);
            3'd3:    prefix_ok = (w.addr == ADR_KEY_A) && (w.data == DAT_KEY_A);
            3'd4:    prefix_ok = (w.addr == ADR_KEY_B) && (w.data == DAT_KEY_B);
            default: prefix_ok = 1'b0;
        endcase
    endfunction

    function automatic logic [2:0] lowest_set(input logic [N_SECTORS-1:0] m);
        logic [2:0] r;
        r = '0;
        for (int i = N_SECTORS - 1; i >= 0; i--) begin
            if (m[i]) r = 3'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/flash_bus_if.sv
module flash_bus_if
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] din,
    output logic              wr_valid,
    output bus_wr_t           wr
);

    localparam int N_STROBES = 3;

    logic [N_STROBES-1:0] raw_strobe;
    logic [N_STROBES-1:0] sync_strobe;

    assign raw_strobe = {oe_n, we_n, ce_n};

    // One synchronizer chain per strobe; the idle level of every strobe is high.
    for (genvar g = 0; g < N_STROBES; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[SYNC_STAGES-2:0], raw_strobe[g]};
        end
        assign sync_strobe[g] = chain[SYNC_STAGES-1];
    end

    logic s_ce_n, s_we_n, s_oe_n;
    assign s_ce_n = sync_strobe[0];
    assign s_we_n = sync_strobe[1];
    assign s_oe_n = sync_strobe[2];

    logic              wr_act;
    logic              act_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] data_q;

    assign wr_act = !s_ce_n && !s_we_n && s_oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
            wr_valid <= 1'b0;
            wr       <= '0;
        end else begin
            act_q    <= wr_act;
            wr_valid <= 1'b0;
            if (wr_act && !act_q) addr_q <= addr;
            if (wr_act)           data_q <= din;
            // Completion is the first enable rising while output-enable stays high.
            if (act_q && !wr_act && s_oe_n) begin
                wr_valid <= 1'b1;
                wr.addr  <= WIDE_W'(addr_q);
                wr.data  <= data_q;
            end
        end
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_erase_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       block,
    input  logic       wr_valid,
    input  bus_wr_t    wr,
    output erase_cmd_t cmd
);

    logic [2:0] step;

    always_ff @(posedge clk) begin
        if (rst) begin
            step <= '0;
            cmd  <= '0;
        end else begin
            cmd.valid <= 1'b0;
            if (block) begin
                step <= '0;
            end else if (wr_valid) begin
                if (wr.data == DAT_ABORT) begin
                    step <= '0;
                end else if (step < 3'(LAST_STEP)) begin
                    step <= prefix_ok(step, wr) ? step + 3'd1 : 3'd0;
                end else begin
                    step <= '0;
                    if (wr.addr == ADR_KEY_A && wr.data == DAT_CHIP) begin
                        cmd.valid <= 1'b1;
                        cmd.kind  <= OP_CHIP;
                        cmd.addr  <= wr.addr;
                    end else if (wr.data == DAT_SECTOR) begin
                        cmd.valid <= 1'b1;
                        cmd.kind  <= OP_SECTOR;
                        cmd.addr  <= wr.addr;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W       = 17,
    parameter int ERASE_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_lock,
    input  erase_cmd_t        cmd,
    output logic              busy,
    output logic              ers_start,
    output logic [ADDR_W-1:0] ers_first,
    output logic [ADDR_W-1:0] ers_last
);

    localparam int CNT_W = $clog2(ERASE_CYCLES + 1);

    seq_state_e             state;
    logic [N_SECTORS-1:0]   pending;
    logic [CNT_W-1:0]       remain;
    logic [N_SECTORS-1:0]   plan;
    logic [2:0]             pick;
    sector_e                target;
    logic [WIDE_W-1:0]      lo_w, hi_w;

    assign target = sector_of(ADDR_W, cmd.addr);
    assign pick   = lowest_set(pending);
    assign lo_w   = sector_lo(ADDR_W, int'(pick));
    assign hi_w   = sector_hi(ADDR_W, int'(pick));

    always_comb begin
        plan = '0;
        if (cmd.kind == OP_CHIP) begin
            plan = '1;
            if (boot_lock) plan[SEC_BOOT] = 1'b0;
        end else if (cmd.kind == OP_SECTOR) begin
            plan[target] = 1'b1;
            if (boot_lock && target == SEC_BOOT) plan = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            pending   <= '0;
            remain    <= '0;
            ers_start <= 1'b0;
            ers_first <= '0;
            ers_last  <= '0;
        end else begin
            ers_start <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (cmd.valid && plan != '0) begin
                        pending <= plan;
                        state   <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: begin
                    ers_start      <= 1'b1;
                    ers_first      <= lo_w[ADDR_W-1:0];
                    ers_last       <= hi_w[ADDR_W-1:0];
                    pending[pick]  <= 1'b0;
                    remain         <= CNT_W'(ERASE_CYCLES - 1);
                    state          <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (remain == '0)
                        state <= (pending == '0) ? SQ_IDLE : SQ_ISSUE;
                    else
                        remain <= remain - 1'b1;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign busy = (state != SQ_IDLE);

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W       = 17,
    parameter int ERASE_CYCLES = 1000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              boot_lock,
    output logic              dout_en,
    output logic              busy,
    output logic              ers_start,
    output logic [ADDR_W-1:0] ers_first,
    output logic [ADDR_W-1:0] ers_last
);

    logic       wr_valid;
    bus_wr_t    wr;
    erase_cmd_t cmd;

    flash_bus_if #(
        .ADDR_W      (ADDR_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_bus (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .addr     (addr),
        .din      (din),
        .wr_valid (wr_valid),
        .wr       (wr)
    );

    flash_cmd_seq u_cmd (
        .clk      (clk),
        .rst      (rst),
        .block    (busy),
        .wr_valid (wr_valid),
        .wr       (wr),
        .cmd      (cmd)
    );

    flash_erase_seq #(
        .ADDR_W       (ADDR_W),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .boot_lock (boot_lock),
        .cmd       (cmd),
        .busy      (busy),
        .ers_start (ers_start),
        .ers_first (ers_first),
        .ers_last  (ers_last)
    );

    assign dout_en = !rst && !ce_n && !oe_n && we_n;

endmodule

// File: rtl/flash_erase_chk.sv
module flash_erase_chk #(
    parameter int ADDR_W       = 17,
    parameter int ERASE_CYCLES = 1000
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              oe_n,
    input logic              boot_lock,
    input logic              dout_en,
    input logic              busy,
    input logic              ers_start,
    input logic [ADDR_W-1:0] ers_first,
    input logic [ADDR_W-1:0] ers_last
);

    int   gap;
    logic in_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap    <= 0;
            in_run <= 1'b0;
        end else if (ers_start) begin
            gap    <= 1;
            in_run <= 1'b1;
        end else if (!busy) begin
            gap    <= 0;
            in_run <= 1'b0;
        end else begin
            gap <= gap + 1;
        end
    end

    assert_tristate_reset_R2: assert property (@(posedge clk)
        rst |-> !dout_en);

    assert_tristate_ctl_R2: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n) |-> !dout_en);

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
        ers_start |=> !ers_start);

    assert_bounds_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !ers_start && busy |=> (ers_start || ($stable(ers_first) && $stable(ers_last))));

    assert_bounds_order_R6: assert property (@(posedge clk) disable iff (rst)
        ers_start |-> ers_first < ers_last);

    assert_boot_skip_R7: assert property (@(posedge clk) disable iff (rst)
        (ers_start && boot_lock) |-> ers_first != '0);

    assert_start_in_busy_R9: assert property (@(posedge clk) disable iff (rst)
        ers_start |-> busy);

    assert_region_gap_R9: assert property (@(posedge clk) disable iff (rst)
        (ers_start && in_run) |-> gap == ERASE_CYCLES + 1);

    assert_abort_R11: assert property (@(posedge clk)
        rst |=> (!busy && !ers_start));

endmodule

bind flash_erase_ctrl flash_erase_chk #(
    .ADDR_W       (ADDR_W),
    .ERASE_CYCLES (ERASE_CYCLES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .boot_lock (boot_lock),
    .dout_en   (dout_en),
    .busy      (busy),
    .ers_start (ers_start),
    .ers_first (ers_first),
    .ers_last  (ers_last)
);

// File: tb/test_flash_erase_ctrl.sv
`timescale 1ns/1ps
module test_flash_erase_ctrl;

    localparam int AW = 17;
    localparam int NC = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic          boot_lock = 1'b0;
    logic          dout_en, busy, ers_start;
    logic [AW-1:0] ers_first, ers_last;

    int total = 0;
    int bad   = 0;
    int n_st  = 0;
    int busy_cyc = 0;
    logic [AW-1:0] rec_lo [8];
    logic [AW-1:0] rec_hi [8];

    always #10 clk = ~clk;

    flash_erase_ctrl #(.ADDR_W(AW), .ERASE_CYCLES(NC), .SYNC_STAGES(2)) i_flash_erase_ctrl (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .boot_lock(boot_lock),
        .dout_en(dout_en), .busy(busy), .ers_start(ers_start),
        .ers_first(ers_first), .ers_last(ers_last)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_cyc++;
            if (ers_start) begin
                if (n_st < 8) begin
                    rec_lo[n_st] = ers_first;
                    rec_hi[n_st] = ers_last;
                end
                n_st++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic longint s_lo(input int i);
        case (i)
            0: return 0;
            1: return longint'(1) << (AW - 3);
            2: return (longint'(1) << (AW - 3)) + (longint'(1) << (AW - 4));
            3: return longint'(1) << (AW - 2);
            default: return longint'(1) << (AW - 1);
        endcase
    endfunction

    function automatic longint s_hi(input int i);
        if (i == 4) return (longint'(1) << AW) - 1;
        return s_lo(i + 1) - 1;
    endfunction

    task automatic clear_rec;
        n_st = 0;
        busy_cyc = 0;
    endtask

    // mode 0: ce falls first, we falls last and rises first; mode 1 swaps them.
    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d, input int mode);
        @(negedge clk);
        addr = a; din = d;
        if (mode == 0) ce_n = 1'b0; else we_n = 1'b0;
        repeat (2) @(negedge clk);
        if (mode == 0) we_n = 1'b0; else ce_n = 1'b0;
        repeat (5) @(negedge clk);
        if (mode == 0) we_n = 1'b1; else ce_n = 1'b1;
        repeat (2) @(negedge clk);
        if (mode == 0) ce_n = 1'b1; else we_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic prefix(input int upto);
        if (upto > 0) bus_write(17'h05555, 8'hAA, 0);
        if (upto > 1) bus_write(17'h02AAA, 8'h55, 1);
        if (upto > 2) bus_write(17'h05555, 8'h80, 0);
        if (upto > 3) bus_write(17'h05555, 8'hAA, 1);
        if (upto > 4) bus_write(17'h02AAA, 8'h55, 0);
    endtask

    task automatic settle;
        repeat (10) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_cmd(input logic [AW-1:0] a6, input logic [7:0] d6);
        clear_rec();
        prefix(5);
        bus_write(a6, d6, 0);
        settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R9 actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // Reset state (R2, R11)
        oe_n = 1'b0;
        @(negedge clk);
        check(dout_en == 1'b0, "R2 dout_en low in reset", dout_en, 0);
        oe_n = 1'b1;
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R11 busy after reset", busy, 0);
        check(ers_start == 1'b0, "R11 start after reset", ers_start, 0);

        // R2 read enable over all strobe combinations
        for (int c = 0; c < 8; c++) begin
            ce_n = c[0]; oe_n = c[1]; we_n = c[2];
            #1;
            check(dout_en == (c == 4), "R2 dout_en gating", dout_en, (c == 4));
        end
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;

        // R6 / R4 / R7: sector erase sweep, both lockout settings
        for (int lk = 0; lk < 2; lk++) begin
            boot_lock = lk[0];
            for (int s = 0; s < 5; s++) begin
                for (int p = 0; p < 3; p++) begin
                    longint a;
                    bit     skip;
                    a = (p == 0) ? s_lo(s) : (p == 1) ? s_hi(s) : (s_lo(s) + s_hi(s)) / 2;
                    skip = (lk == 1) && (s == 0);
                    run_cmd(AW'(a), 8'h30);
                    check(n_st == (skip ? 0 : 1), "R7 R4 sector erase start count", n_st, skip ? 0 : 1);
                    check(busy_cyc == (skip ? 0 : NC + 1), "R9 sector busy length", busy_cyc, skip ? 0 : NC + 1);
                    if (!skip && n_st == 1) begin
                        check(rec_lo[0] == AW'(s_lo(s)), "R6 sector first", rec_lo[0], s_lo(s));
                        check(rec_hi[0] == AW'(s_hi(s)), "R6 sector last", rec_hi[0], s_hi(s));
                    end
                end
            end
        end

        // R3 / R7 / R8 / R9: chip erase with both lockout settings
        for (int lk = 0; lk < 2; lk++) begin
            int k;
            boot_lock = lk[0];
            run_cmd(17'h05555, 8'h10);
            k = (lk == 1) ? 4 : 5;
            check(n_st == k, "R3 R7 chip erase region count", n_st, k);
            check(busy_cyc == k * (NC + 1), "R9 chip busy length", busy_cyc, k * (NC + 1));
            for (int r = 0; r < k && r < n_st; r++) begin
                check(rec_lo[r] == AW'(s_lo(r + lk)), "R8 region order first", rec_lo[r], s_lo(r + lk));
                check(rec_hi[r] == AW'(s_hi(r + lk)), "R8 region order last", rec_hi[r], s_hi(r + lk));
            end
        end
        boot_lock = 1'b0;

        // R4: sixth write with wrong data starts nothing
        run_cmd(17'h09000, 8'h20);
        check(n_st == 0, "R4 wrong sixth data", n_st, 0);

        // R5: mismatch mid-prefix, then the remainder of a sequence
        clear_rec();
        prefix(2);
        bus_write(17'h05555, 8'h81, 0);
        bus_write(17'h05555, 8'hAA, 1);
        bus_write(17'h02AAA, 8'h55, 0);
        bus_write(17'h05555, 8'h10, 0);
        settle();
        check(n_st == 0, "R5 mismatch resets decoder", n_st, 0);

        // R5: abort data at step four
        clear_rec();
        prefix(3);
        bus_write(17'h05555, 8'hF0, 0);
        bus_write(17'h02AAA, 8'h55, 0);
        bus_write(17'h05555, 8'h10, 0);
        settle();
        check(n_st == 0, "R5 abort data resets decoder", n_st, 0);

        // R5: recovery with a full sequence afterwards
        run_cmd(17'h06100, 8'h30);
        check(n_st == 1 && rec_lo[0] == AW'(s_lo(2)), "R5 recovery after abort", rec_lo[0], s_lo(2));

        // R1: strobe pulse with output-enable low is not a write
        clear_rec();
        oe_n = 1'b0;
        bus_write(17'h05555, 8'hAA, 0);
        oe_n = 1'b1;
        prefix(5);
        bus_write(17'h10000, 8'h30, 0);
        settle();
        check(n_st == 1, "R1 oe-low pulse ignored", n_st, 1);

        // R1: address taken at the later fall, data at the earlier rise
        clear_rec();
        prefix(5);
        @(negedge clk);
        addr = 17'h00100; din = 8'h00;
        ce_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b0;
        repeat (5) @(negedge clk);
        addr = 17'h1F000;
        din = 8'h30;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        repeat (2) @(negedge clk);
        din = 8'h77;
        ce_n = 1'b1;
        settle();
        check(n_st == 1, "R1 write capture start count", n_st, 1);
        check(rec_lo[0] == AW'(s_lo(0)), "R1 address at later fall", rec_lo[0], s_lo(0));

        // R10: a whole sequence entered during a chip erase is ignored
        clear_rec();
        prefix(5);
        bus_write(17'h05555, 8'h10, 0);
        repeat (4) @(negedge clk);
        check(busy == 1'b1, "R10 busy during erase", busy, 1);
        prefix(5);
        bus_write(17'h08000, 8'h30, 0);
        settle();
        repeat (60) @(negedge clk);
        check(n_st == 5, "R10 writes ignored while busy", n_st, 5);
        ce_n = 1'b0; oe_n = 1'b0;
        #1;
        check(dout_en == 1'b1, "R10 read mode after erase", dout_en, 1);
        ce_n = 1'b1; oe_n = 1'b1;
        run_cmd(17'h00010, 8'h30);
        check(n_st == 1 && rec_hi[0] == AW'(s_hi(0)), "R10 decoder idle after erase", rec_hi[0], s_hi(0));

        // R11: reset during a chip erase
        clear_rec();
        prefix(5);
        bus_write(17'h05555, 8'h10, 0);
        while (n_st < 2) @(negedge clk);
        rst = 1'b1;
        ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        check(dout_en == 1'b0, "R11 outputs off in reset", dout_en, 0);
        check(busy == 1'b0, "R11 busy cleared", busy, 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(dout_en == 1'b1, "R11 read mode after reset", dout_en, 1);
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (120) @(negedge clk);
        check(n_st == 2, "R11 aborted regions not requested", n_st, 2);

        // R11: reset clears a partly entered sequence
        clear_rec();
        prefix(3);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        bus_write(17'h05555, 8'hAA, 1);
        bus_write(17'h02AAA, 8'h55, 0);
        bus_write(17'h05555, 8'h10, 0);
        settle();
        check(n_st == 0, "R11 reset clears sequence", n_st, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule